// File: doc/BRIEF.md
# System Bus Error Recorder

This block watches the error lines of a shared system bus. The lines report address errors and data parity errors. Each reported error goes into one of four sticky bits. Errors on transactions this board started are kept apart from errors on transactions that other boards started. An ownership input, asserted while this board drives the current transaction, tells the two cases apart.

Only one case raises an interrupt: an address error that a receiver reports against this board's own transaction. The interrupt is a one-cycle request. It goes out with a priority and a destination taken from a programmable configuration word.

Software reaches the error word and the configuration word through a small register port with one select bit. Reading the error word leaves it unchanged. Writing to the error word, whatever the data, clears all four bits.

Top module: `busfault_tracker`

## Requirements
- R1: After a synchronous reset, the error word reads 0, the configuration word reads 0x13422 and `irq_req` is low.
- R2: An address error while `own_txn` is high sets error bit 3. When configuration bit 16 (enable) is set, it also drives `irq_req` high in the next cycle.
- R3: A data parity error while `own_txn` is high sets error bit 2 and never raises `irq_req`.
- R4: While `own_txn` is low, an address error sets error bit 1 and a data parity error sets error bit 0. Neither raises `irq_req`.
- R5: Error bits stay set until software clears them. Reads and configuration writes leave them unchanged.
- R6: A write with `cfg_sel`=0 clears all four error bits, whatever value `cfg_wdata` carries.
- R7: An error that arrives in the same cycle as a clearing write is kept, and its bit reads 1 afterwards.
- R8: A write with `cfg_sel`=1 stores the configuration word. The layout is enable at bit 16, priority at bits 15:8 and destination at bits 6:0. Bit 7 always reads 0.
- R9: `irq_req` is a one-cycle pulse for each cycle that carries a qualifying error. When the enable bit is 0, `irq_req` stays low.
- R10: `irq_prio` and `irq_dest` always show the priority and destination fields of the stored configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_err | input | 1 | An address error is reported on the bus this cycle |
| bus_data_err | input | 1 | A data parity error is reported on the bus this cycle |
| own_txn | input | 1 | This board initiated the current transaction |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = error word, 1 = interrupt configuration |
| cfg_wdata | input | 17 | Register write data |
| cfg_rdata | output | 17 | Read data of the selected register (error word zero-extended) |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_prio | output | 8 | Interrupt priority |
| irq_dest | output | 7 | Interrupt destination |

## Verification
The embedded properties check several behaviours on every cycle:
- how each error is routed to its bit, split by ownership;
- that bits stay set when no clear occurs;
- that a clear wins only when no new error arrives with it;
- that a sender-side address error with enable set always pulses the interrupt, and that nothing else ever does;
- that the configuration word holds when it is not written.

Other behaviours only the directed scenarios can show:
- the exact reset values read through the port;
- bit 7 reading back as zero;
- the priority and destination outputs following a write;
- the interrupt staying silent once it is disabled;
- back-to-back pulses ending after the last error.

// File: rtl/busfault_pkg.sv
package busfault_pkg;

    localparam int PRIO_W   = 8;
    localparam int DEST_W   = 7;
    localparam int CFG_W    = 1 + PRIO_W + 1 + DEST_W;
    localparam int ERR_W    = 4;

    localparam logic [CFG_W-1:0] CFG_RESET = 17'h13422;

    // Bit order is software-visible: 3 own-address, 2 own-data, 1 foreign-address, 0 foreign-data
    typedef struct packed {
        logic own_addr;
        logic own_data;
        logic oth_addr;
        logic oth_data;
    } err_word_t;

    typedef struct packed {
        logic              enable;
        logic [PRIO_W-1:0] prio;
        logic              pad;
        logic [DEST_W-1:0] dest;
    } irq_cfg_t;

    typedef enum logic {
        SEL_ERR = 1'b0,
        SEL_CFG = 1'b1
    } cfg_sel_e;

    function automatic err_word_t classify(input logic own, input logic addr, input logic data);
        err_word_t e;
        e.own_addr = own  & addr;
        e.own_data = own  & data;
        e.oth_addr = !own & addr;
        e.oth_data = !own & data;
        return e;
    endfunction

    function automatic irq_cfg_t sanitize(input logic [CFG_W-1:0] raw);
        irq_cfg_t c;
        c     = irq_cfg_t'(raw);
        c.pad = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/busfault_capture.sv
module busfault_capture
    import busfault_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  err_word_t new_err,
    input  logic      clr,
    output err_word_t err_q
);

    // A fresh error beats a clear arriving in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (clr) begin
            err_q <= new_err;
        end else begin
            err_q <= err_q | new_err;
        end
    end

    p_own_addr_r2: assert property (@(posedge clk) disable iff (rst)
        new_err.own_addr |=> err_q.own_addr);

    p_own_data_r3: assert property (@(posedge clk) disable iff (rst)
        new_err.own_data |=> err_q.own_data);

    p_foreign_r4: assert property (@(posedge clk) disable iff (rst)
        (new_err.oth_addr || new_err.oth_data) |=>
            (err_q.oth_addr || err_q.oth_data));

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((err_q & $past(err_q)) == $past(err_q)));

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr && new_err == '0) |=> (err_q == '0));

    p_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && new_err.own_addr) |=> err_q.own_addr);

endmodule

// File: rtl/busfault_cfg.sv
module busfault_cfg
    import busfault_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_VAL = CFG_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output irq_cfg_t         cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= sanitize(RESET_VAL);
        end else if (wr) begin
            cfg_q <= sanitize(wdata);
        end
    end

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cfg_q));

endmodule

// File: rtl/busfault_irq.sv
module busfault_irq
    import busfault_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  err_word_t new_err,
    input  logic      enable,
    output logic      irq_q
);

    logic fire;

    // Only a sender-side address error qualifies
    assign fire = new_err.own_addr & enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= fire;
        end
    end

    p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (enable && new_err.own_addr) |=> irq_q);

    p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
        !(enable && new_err.own_addr) |=> !irq_q);

endmodule

// File: rtl/busfault_tracker.sv
module busfault_tracker
    import busfault_pkg::*;
#(
    parameter logic [CFG_W-1:0] CFG_INIT = CFG_RESET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_addr_err,
    input  logic              bus_data_err,
    input  logic              own_txn,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic              irq_req,
    output logic [PRIO_W-1:0] irq_prio,
    output logic [DEST_W-1:0] irq_dest
);

    localparam int PAD_W = CFG_W - ERR_W;

    err_word_t new_err;
    err_word_t err_q;
    irq_cfg_t  cfg_q;
    cfg_sel_e  sel;
    logic      clr_err;
    logic      wr_cfg;

    assign sel     = cfg_sel_e'(cfg_sel);
    assign new_err = classify(own_txn, bus_addr_err, bus_data_err);
    assign clr_err = cfg_wr && (sel == SEL_ERR);
    assign wr_cfg  = cfg_wr && (sel == SEL_CFG);

    busfault_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .new_err (new_err),
        .clr     (clr_err),
        .err_q   (err_q)
    );

    busfault_cfg #(
        .RESET_VAL (CFG_INIT)
    ) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_cfg),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    busfault_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .new_err (new_err),
        .enable  (cfg_q.enable),
        .irq_q   (irq_req)
    );

    always_comb begin
        unique case (sel)
            SEL_ERR: cfg_rdata = {{PAD_W{1'b0}}, err_q};
            SEL_CFG: cfg_rdata = cfg_q;
            default: cfg_rdata = '0;
        endcase
    end

    assign irq_prio = cfg_q.prio;
    assign irq_dest = cfg_q.dest;

    p_irq_only_sender_r9: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> $past(own_txn && bus_addr_err));

endmodule

// File: tb/test_busfault_tracker.sv
`timescale 1ns/1ps
module test_busfault_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_addr_err = 1'b0;
    logic        bus_data_err = 1'b0;
    logic        own_txn = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [16:0] cfg_wdata = '0;
    logic [16:0] cfg_rdata;
    logic        irq_req;
    logic [7:0]  irq_prio;
    logic [6:0]  irq_dest;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    busfault_tracker i_busfault_tracker (
        .clk(clk), .rst(rst),
        .bus_addr_err(bus_addr_err), .bus_data_err(bus_data_err), .own_txn(own_txn),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_req(irq_req), .irq_prio(irq_prio), .irq_dest(irq_dest)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic read_err(output logic [16:0] v);
        cfg_sel = 1'b0;
        #0 v = cfg_rdata;
        #1 v = cfg_rdata;
    endtask

    // Present one error cycle, then sample after the capturing edge
    task automatic bus_err(input logic own, input logic a, input logic d);
        @(negedge clk);
        own_txn = own; bus_addr_err = a; bus_data_err = d;
        @(negedge clk);
        own_txn = 1'b0; bus_addr_err = 1'b0; bus_data_err = 1'b0;
    endtask

    task automatic wr_reg(input logic sel, input logic [16:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic clear_err();
        wr_reg(1'b0, 17'h1FFFF);
    endtask

    task automatic t_reset();
        logic [16:0] v;
        read_err(v);
        chk("R1 error word", v, 0);
        cfg_sel = 1'b1; #1;
        chk("R1 config word", cfg_rdata, 17'h13422);
        chk("R1 irq low", irq_req, 0);
        chk("R10 prio", irq_prio, 8'h34);
        chk("R10 dest", irq_dest, 7'h22);
    endtask

    task automatic t_own_addr();
        logic [16:0] v;
        bus_err(1, 1, 0);
        chk("R2 irq pulse", irq_req, 1);
        read_err(v);
        chk("R2 bit3", v, 17'h8);
        @(negedge clk);
        chk("R9 pulse ends", irq_req, 0);
        clear_err();
    endtask

    task automatic t_own_data();
        logic [16:0] v;
        bus_err(1, 0, 1);
        chk("R3 no irq", irq_req, 0);
        read_err(v);
        chk("R3 bit2", v, 17'h4);
        clear_err();
    endtask

    task automatic t_foreign();
        logic [16:0] v;
        bus_err(0, 1, 0);
        chk("R4 no irq addr", irq_req, 0);
        read_err(v);
        chk("R4 bit1", v, 17'h2);
        bus_err(0, 0, 1);
        chk("R4 no irq data", irq_req, 0);
        read_err(v);
        chk("R4 bits1+0", v, 17'h3);
        clear_err();
    endtask

    task automatic t_sticky_clear();
        logic [16:0] v;
        bus_err(1, 1, 1);
        @(negedge clk); @(negedge clk);
        cfg_sel = 1'b1; #1;
        read_err(v);
        chk("R5 sticky after idle", v, 17'hC);
        wr_reg(1'b1, 17'h13422);
        read_err(v);
        chk("R5 sticky after cfg write", v, 17'hC);
        wr_reg(1'b0, 17'h00000);
        read_err(v);
        chk("R6 cleared by zero data", v, 0);
        bus_err(0, 1, 1);
        wr_reg(1'b0, 17'h0000F);
        read_err(v);
        chk("R6 cleared by ones data", v, 0);
    endtask

    task automatic t_collision();
        logic [16:0] v;
        bus_err(0, 0, 1);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = '0;
        own_txn = 1'b1; bus_addr_err = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; own_txn = 1'b0; bus_addr_err = 1'b0;
        chk("R7 irq with clear", irq_req, 1);
        read_err(v);
        chk("R7 new kept, old cleared", v, 17'h8);
        clear_err();
    endtask

    task automatic t_cfg();
        wr_reg(1'b1, 17'h1FFFF);
        cfg_sel = 1'b1; #1;
        chk("R8 bit7 reads zero", cfg_rdata, 17'h1FF7F);
        chk("R10 prio follows", irq_prio, 8'hFF);
        chk("R10 dest follows", irq_dest, 7'h7F);
        wr_reg(1'b1, 17'h0A555);
        cfg_sel = 1'b1; #1;
        chk("R8 stored pattern", cfg_rdata, 17'h0A555);
        chk("R10 prio pattern", irq_prio, 8'hA5);
        chk("R10 dest pattern", irq_dest, 7'h55);
    endtask

    task automatic t_disabled();
        logic [16:0] v;
        bus_err(1, 1, 0);
        chk("R9 disabled no irq", irq_req, 0);
        read_err(v);
        chk("R9 bit still set", v, 17'h8);
        clear_err();
        wr_reg(1'b1, 17'h13422);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        own_txn = 1; bus_addr_err = 1;
        @(negedge clk);
        chk("R9 first pulse", irq_req, 1);
        @(negedge clk);
        own_txn = 0; bus_addr_err = 0;
        chk("R9 second pulse", irq_req, 1);
        @(negedge clk);
        chk("R9 ends after last", irq_req, 0);
        clear_err();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_own_addr();
        t_own_data();
        t_foreign();
        t_sticky_clear();
        t_collision();
        t_cfg();
        t_disabled();
        t_back_to_back();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule